// File: doc/BRIEF.md
# LCD Window Update Sequencer

This block pushes a rectangular partial-screen update to a small display controller over a four-wire serial link with a separate data/command select line. A single `start` pulse captures a rectangle: first and stop columns, and first and stop rows, where each stop value is exclusive. It also captures a left offset and a top offset. The block then sends three framed transactions. Each frame is a command byte followed by its payload. The first frame sets the column window, the second sets the row window, and the third writes memory and carries the pixels.

Pixels enter as 16-bit words on a valid/ready handshake. Each pixel leaves high byte first, and every byte leaves most significant bit first in serial mode 0. Command bytes and short payloads are clocked at a slow serial rate. A pixel payload longer than a threshold is clocked at a fast rate. A one-cycle `done` pulse marks the end of the last pixel bit.

The caller must supply stop > first on both axes. `FAST_HALF` must not exceed `SLOW_HALF`.

Top module: `lcd_window_sender`

## Requirements
- R1: After reset, `cs_n` is 1 and `sclk`, `busy`, `done` and `pix_ready` are 0.
- R2: Frame 0 carries command 0x2A followed by four bytes. Each coordinate has the left offset added. The bytes are, in order: start high, start low, end high, end low. The start is `col_first`+offset and the end is `col_stop`-1+offset, both 16 bits wide.
- R3: Frame 1 carries command 0x2B with the same four-byte layout, built from the row coordinates plus the top offset.
- R4: Frame 2 carries command 0x2C followed by exactly 2×W×H bytes, where W = `col_stop`-`col_first` and H = `row_stop`-`row_first`. Pixels appear in the order they were accepted, and each pixel's high byte is sent before its low byte.
- R5: `dc` is 0 while a command byte is shifted and 1 while a parameter or pixel byte is shifted. `dc` never changes while `sclk` is high.
- R6: `cs_n` is low throughout one command and its payload. It goes high between frames for at least 2×`SLOW_HALF` clock cycles. It is high whenever the block is idle, and `sclk` is never high while `cs_n` is high.
- R7: Mode 0 timing applies: `sclk` idles low, `mosi` changes only while `sclk` is low, and bits go out MSB first.
- R8: Command bytes, coordinate bytes, and pixel payloads of at most `LONG_LIMIT` bytes use an `sclk` high time of `SLOW_HALF` cycles. Pixel payloads longer than `LONG_LIMIT` bytes use `FAST_HALF` cycles.
- R9: `pix_ready` is high only in the pixel phase and only while the byte shifter is free. A pixel is taken on a cycle where `pix_valid` and `pix_ready` are both high.
- R10: `done` is a single-cycle pulse raised after the last pixel bit. `busy` is low in that cycle.
- R11: A `start` pulse while `busy` is high is ignored. Coordinates are captured only when the block accepts a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an update (taken when idle) |
| col_first | input | COORD_W | First column, inclusive |
| col_stop | input | COORD_W | Column edge, exclusive |
| row_first | input | COORD_W | First row, inclusive |
| row_stop | input | COORD_W | Row edge, exclusive |
| left_off | input | COORD_W | Added to both column coordinates |
| top_off | input | COORD_W | Added to both row coordinates |
| pix_data | input | 16 | Pixel word |
| pix_valid | input | 1 | Pixel word present |
| pix_ready | output | 1 | Block takes a pixel this cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| dc | output | 1 | 0 = command byte, 1 = data byte |
| busy | output | 1 | Update in progress |
| done | output | 1 | Pulse after the final pixel bit |

## Verification
The sweep covers several window patterns, each aimed at a different risk:
- A single pixel exercises the shortest payload.
- A payload of exactly the threshold (64 bytes) and one just above it (66 bytes) separate the slow and fast clock choice at the boundary.
- Offsets that carry into the high coordinate byte, including one window at the top of the coordinate range, expose byte-order and carry mistakes in the window commands.
- Irregular pixel stalls check the handshake against pixel reordering.
- A second start injected mid-transfer with different coordinates must leave the byte stream unchanged.

The serial stream is decoded at the pins into bytes tagged with frame, `dc` and high time, then compared with a stream built arithmetically from the request.

// File: rtl/lcd_win_pkg.sv
package lcd_win_pkg;

  localparam logic [7:0] CMD_COL_WIN = 8'h2A;
  localparam logic [7:0] CMD_ROW_WIN = 8'h2B;
  localparam logic [7:0] CMD_MEM_WR  = 8'h2C;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_CMD, ST_PAR, ST_PIXW, ST_PIX
  } seq_state_t;

  // command byte of frame n (0 column, 1 row, 2 memory write)
  function automatic logic [7:0] frame_cmd(input logic [1:0] n);
    case (n)
      2'd0:    return CMD_COL_WIN;
      2'd1:    return CMD_ROW_WIN;
      default: return CMD_MEM_WR;
    endcase
  endfunction

  // window parameter byte k: start hi, start lo, end hi, end lo
  function automatic logic [7:0] win_param(input logic [15:0] first,
                                           input logic [15:0] last,
                                           input logic [1:0]  k);
    case (k)
      2'd0:    return first[15:8];
      2'd1:    return first[7:0];
      2'd2:    return last[15:8];
      default: return last[7:0];
    endcase
  endfunction

endpackage

// File: rtl/lcd_byte_shifter.sv
module lcd_byte_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       din,
  input  logic [DIV_W-1:0] half,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             done
);
  logic [7:0]       sh;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bits;

  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      cnt  <= '0;
      bits <= '0;
      sclk <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (load) begin
          sh   <= din;
          cnt  <= '0;
          bits <= '0;
          sclk <= 1'b0;
          busy <= 1'b1;
        end
      end else if (cnt == half - DIV_W'(1)) begin
        cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (bits == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bits <= bits + 3'd1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/lcd_win_axis.sv
module lcd_win_axis #(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [COORD_W-1:0] lo,
  input  logic [COORD_W-1:0] hi,
  input  logic [COORD_W-1:0] off,
  output logic [15:0]        first,
  output logic [15:0]        last,
  output logic [COORD_W-1:0] span
);
  localparam int PAD = 16 - COORD_W;

  logic [15:0] lo_w, hi_w, off_w;
  assign lo_w  = {{PAD{1'b0}}, lo};
  assign hi_w  = {{PAD{1'b0}}, hi};
  assign off_w = {{PAD{1'b0}}, off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first <= '0;
      last  <= '0;
      span  <= '0;
    end else if (capture) begin
      first <= lo_w + off_w;
      last  <= hi_w - 16'd1 + off_w;
      span  <= hi - lo;
    end
  end
endmodule

// File: rtl/lcd_win_seq.sv
module lcd_win_seq
  import lcd_win_pkg::*;
#(
  parameter int PCNT_W  = 20,
  parameter int GAP_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0][15:0]  win_first,
  input  logic [1:0][15:0]  win_last,
  input  logic [PCNT_W-1:0] pix_total,
  input  logic              pix_long,
  input  logic [15:0]       pix_data,
  input  logic              pix_valid,
  input  logic              byte_done,
  output logic              capture,
  output logic              pix_ready,
  output logic              load,
  output logic [7:0]        tx_byte,
  output logic              fast_sel,
  output logic              cs_n,
  output logic              dc,
  output logic              busy,
  output logic              done
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  seq_state_t        st;
  logic [1:0]        cmd_i;
  logic [1:0]        par_i;
  logic [GAP_W-1:0]  gap;
  logic [PCNT_W-1:0] left;
  logic [7:0]        low_q;
  logic              second;

  assign busy      = (st != ST_IDLE);
  assign capture   = (st == ST_IDLE) && start;
  assign pix_ready = (st == ST_PIXW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cmd_i    <= '0;
      par_i    <= '0;
      gap      <= '0;
      left     <= '0;
      low_q    <= '0;
      second   <= 1'b0;
      load     <= 1'b0;
      tx_byte  <= '0;
      fast_sel <= 1'b0;
      cs_n     <= 1'b1;
      dc       <= 1'b0;
      done     <= 1'b0;
    end else begin
      load <= 1'b0;
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          cmd_i <= '0;
          gap   <= '0;
          st    <= ST_GAP;
        end
        ST_GAP: if (gap == GAP_W'(GAP_CYC - 1)) begin
          cs_n     <= 1'b0;
          dc       <= 1'b0;
          fast_sel <= 1'b0;
          tx_byte  <= frame_cmd(cmd_i);
          load     <= 1'b1;
          st       <= ST_CMD;
        end else begin
          gap <= gap + GAP_W'(1);
        end
        ST_CMD: if (byte_done) begin
          dc <= 1'b1;
          if (cmd_i == 2'd2) begin
            left <= pix_total;
            st   <= ST_PIXW;
          end else begin
            par_i   <= '0;
            tx_byte <= win_param(win_first[cmd_i[0]], win_last[cmd_i[0]], 2'd0);
            load    <= 1'b1;
            st      <= ST_PAR;
          end
        end
        ST_PAR: if (byte_done) begin
          if (par_i == 2'd3) begin
            cs_n  <= 1'b1;
            cmd_i <= cmd_i + 2'd1;
            gap   <= '0;
            st    <= ST_GAP;
          end else begin
            par_i   <= par_i + 2'd1;
            tx_byte <= win_param(win_first[cmd_i[0]], win_last[cmd_i[0]],
                                 par_i + 2'd1);
            load    <= 1'b1;
          end
        end
        ST_PIXW: if (pix_valid) begin
          tx_byte  <= pix_data[15:8];
          low_q    <= pix_data[7:0];
          second   <= 1'b0;
          fast_sel <= pix_long;
          load     <= 1'b1;
          st       <= ST_PIX;
        end
        ST_PIX: if (byte_done) begin
          if (!second) begin
            tx_byte <= low_q;
            second  <= 1'b1;
            load    <= 1'b1;
          end else if (left == PCNT_W'(1)) begin
            cs_n <= 1'b1;
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            left <= left - PCNT_W'(1);
            st   <= ST_PIXW;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_window_sender.sv
module lcd_window_sender #(
  parameter int COORD_W    = 10,
  parameter int DIV_W      = 8,
  parameter int SLOW_HALF  = 3,
  parameter int FAST_HALF  = 1,
  parameter int LONG_LIMIT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [COORD_W-1:0] col_first,
  input  logic [COORD_W-1:0] col_stop,
  input  logic [COORD_W-1:0] row_first,
  input  logic [COORD_W-1:0] row_stop,
  input  logic [COORD_W-1:0] left_off,
  input  logic [COORD_W-1:0] top_off,
  input  logic [15:0]        pix_data,
  input  logic               pix_valid,
  output logic               pix_ready,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n,
  output logic               dc,
  output logic               busy,
  output logic               done
);
  localparam int PCNT_W  = 2 * COORD_W;
  localparam int GAP_CYC = 2 * SLOW_HALF;

  logic [COORD_W-1:0] ax_lo  [2];
  logic [COORD_W-1:0] ax_hi  [2];
  logic [COORD_W-1:0] ax_off [2];
  logic [COORD_W-1:0] ax_span[2];
  logic [1:0][15:0]   win_first, win_last;
  logic [PCNT_W-1:0]  pix_total;
  logic               pix_long;
  logic               capture, load, fast_sel, byte_done, shift_busy;
  logic [7:0]         tx_byte;
  logic [DIV_W-1:0]   half;

  assign ax_lo[0]  = col_first;
  assign ax_hi[0]  = col_stop;
  assign ax_off[0] = left_off;
  assign ax_lo[1]  = row_first;
  assign ax_hi[1]  = row_stop;
  assign ax_off[1] = top_off;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    lcd_win_axis #(.COORD_W(COORD_W)) u_axis (
      .clk    (clk),
      .rst_n  (rst_n),
      .capture(capture),
      .lo     (ax_lo[g]),
      .hi     (ax_hi[g]),
      .off    (ax_off[g]),
      .first  (win_first[g]),
      .last   (win_last[g]),
      .span   (ax_span[g])
    );
  end

  assign pix_total = PCNT_W'(ax_span[0]) * PCNT_W'(ax_span[1]);
  assign pix_long  = {1'b0, pix_total, 1'b0} > (PCNT_W + 2)'(LONG_LIMIT);
  assign half      = fast_sel ? DIV_W'(FAST_HALF) : DIV_W'(SLOW_HALF);

  lcd_win_seq #(.PCNT_W(PCNT_W), .GAP_CYC(GAP_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .win_first(win_first),
    .win_last (win_last),
    .pix_total(pix_total),
    .pix_long (pix_long),
    .pix_data (pix_data),
    .pix_valid(pix_valid),
    .byte_done(byte_done),
    .capture  (capture),
    .pix_ready(pix_ready),
    .load     (load),
    .tx_byte  (tx_byte),
    .fast_sel (fast_sel),
    .cs_n     (cs_n),
    .dc       (dc),
    .busy     (busy),
    .done     (done)
  );

  lcd_byte_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load),
    .din  (tx_byte),
    .half (half),
    .sclk (sclk),
    .mosi (mosi),
    .busy (shift_busy),
    .done (byte_done)
  );
endmodule

// File: rtl/lcd_window_chk.sv
module lcd_window_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic dc,
  input logic pix_ready,
  input logic busy,
  input logic done,
  input logic shift_busy
);
  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);                                      // R6
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);                                      // R6
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));                              // R7
  AST_DC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(dc));                                // R5
  AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (!shift_busy && !cs_n && dc));          // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                      // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n));                            // R10
endmodule

bind lcd_window_sender lcd_window_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk      (sclk),
  .mosi      (mosi),
  .cs_n      (cs_n),
  .dc        (dc),
  .pix_ready (pix_ready),
  .busy      (busy),
  .done      (done),
  .shift_busy(shift_busy)
);

// File: tb/sim_lcd_window_sender.sv
`timescale 1ns/1ps
module sim_lcd_window_sender;
  localparam int CW = 10;
  localparam int SLOW = 3;
  localparam int FAST = 1;
  localparam int LIM = 64;

  logic clk = 0, rst_n = 0, start = 0;
  logic [CW-1:0] col_first = 0, col_stop = 0, row_first = 0, row_stop = 0;
  logic [CW-1:0] left_off = 0, top_off = 0;
  logic [15:0] pix_data = 0;
  logic pix_valid = 0;
  logic pix_ready, sclk, mosi, cs_n, dc, busy, done;

  lcd_window_sender #(.COORD_W(CW), .DIV_W(8), .SLOW_HALF(SLOW),
                      .FAST_HALF(FAST), .LONG_LIMIT(LIM)) u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // serial decoder at the pins
  logic [7:0] cb[0:1023];
  logic       cd[0:1023];
  int         cf[0:1023];
  int         ch[0:1023];
  int ccount, falls, bitn, hcnt, hlen, gap_cur, gap_min;
  int done_seen, done_bytes, mode_err, ready_err;
  logic [7:0] sr;
  logic prev_sclk = 0, prev_cs = 1, prev_mosi = 0;

  task automatic mon_clear();
    ccount = 0; falls = 0; bitn = 0; hcnt = 0; hlen = 0; gap_cur = 0;
    gap_min = 1 << 30; done_seen = 0; done_bytes = 0; mode_err = 0; ready_err = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk) hcnt++;
      else if (prev_sclk) begin hlen = hcnt; hcnt = 0; end
      if (sclk && prev_sclk && mosi != prev_mosi) mode_err++;
      if (sclk && cs_n) mode_err++;
      if (pix_ready && cs_n) ready_err++;
      if (cs_n) gap_cur++;
      if (!cs_n && prev_cs) begin
        if (gap_cur < gap_min) gap_min = gap_cur;
        gap_cur = 0; falls++; bitn = 0;
      end
      if (sclk && !prev_sclk && !cs_n) begin
        sr = {sr[6:0], mosi};
        bitn++;
        if (bitn == 8) begin
          if (ccount < 1024) begin
            cb[ccount] = sr; cd[ccount] = dc; cf[ccount] = falls - 1; ch[ccount] = hlen;
          end
          ccount++; bitn = 0;
        end
      end
      if (done) begin done_seen++; done_bytes = ccount; end
      prev_sclk = sclk; prev_cs = cs_n; prev_mosi = mosi;
    end
  end

  function automatic logic [15:0] pixf(input int i, input logic [15:0] seed);
    return 16'((i + 1) * 40503) ^ seed;
  endfunction

  task automatic run_win(input int x0, input int x1, input int y0, input int y1,
                         input int lo, input int to, input logic [15:0] seed,
                         input bit inject);
    logic [7:0] eb[0:1023];
    logic ed[0:1023];
    int ef[0:1023], eh[0:1023];
    int n, w, h, np, hp, f0;
    int xs, xe, ys, ye;
    w = x1 - x0; h = y1 - y0; np = w * h;
    xs = x0 + lo; xe = x1 - 1 + lo; ys = y0 + to; ye = y1 - 1 + to;
    hp = (2 * np > LIM) ? FAST : SLOW;
    n = 0;
    eb[n] = 8'h2A; ed[n] = 0; ef[n] = 0; eh[n] = SLOW; n++;
    eb[n] = 8'(xs >> 8); ed[n] = 1; ef[n] = 0; eh[n] = SLOW; n++;
    eb[n] = 8'(xs);      ed[n] = 1; ef[n] = 0; eh[n] = SLOW; n++;
    eb[n] = 8'(xe >> 8); ed[n] = 1; ef[n] = 0; eh[n] = SLOW; n++;
    eb[n] = 8'(xe);      ed[n] = 1; ef[n] = 0; eh[n] = SLOW; n++;
    eb[n] = 8'h2B; ed[n] = 0; ef[n] = 1; eh[n] = SLOW; n++;
    eb[n] = 8'(ys >> 8); ed[n] = 1; ef[n] = 1; eh[n] = SLOW; n++;
    eb[n] = 8'(ys);      ed[n] = 1; ef[n] = 1; eh[n] = SLOW; n++;
    eb[n] = 8'(ye >> 8); ed[n] = 1; ef[n] = 1; eh[n] = SLOW; n++;
    eb[n] = 8'(ye);      ed[n] = 1; ef[n] = 1; eh[n] = SLOW; n++;
    eb[n] = 8'h2C; ed[n] = 0; ef[n] = 2; eh[n] = SLOW; n++;
    for (int i = 0; i < np; i++) begin
      logic [15:0] p;
      p = pixf(i, seed);
      eb[n] = p[15:8]; ed[n] = 1; ef[n] = 2; eh[n] = hp; n++;
      eb[n] = p[7:0];  ed[n] = 1; ef[n] = 2; eh[n] = hp; n++;
    end

    mon_clear();
    f0 = fails;
    @(negedge clk);
    col_first = CW'(x0); col_stop = CW'(x1); row_first = CW'(y0); row_stop = CW'(y1);
    left_off = CW'(lo); top_off = CW'(to); start = 1;
    @(negedge clk);
    start = 0;
    fork
      begin
        for (int i = 0; i < np; i++) begin
          if (i % 3 == 1 || (seed[0] && i % 2 == 0)) begin
            pix_valid = 0;
            repeat (2) @(negedge clk);
          end
          pix_valid = 1;
          pix_data = pixf(i, seed);
          while (!pix_ready) @(negedge clk);
          @(negedge clk);
        end
        pix_valid = 0;
        pix_data = 16'hDEAD;
      end
      begin
        if (inject) begin
          repeat (100) @(negedge clk);
          col_first = 0; col_stop = 3; row_first = 0; row_stop = 1;
          left_off = 5; top_off = 5; start = 1;
          @(negedge clk);
          start = 0;
        end
        while (done_seen == 0) @(negedge clk);
      end
    join
    repeat (10) @(negedge clk);

    check(ccount == n, "R4 byte count", ccount, n);
    for (int k = 0; k < n && k < ccount && k < 1024; k++) begin
      string tg;
      tg = (ef[k] == 0) ? "R2" : (ef[k] == 1) ? "R3" : "R4";
      check(cb[k] == eb[k], $sformatf("%s byte %0d", tg, k), cb[k], eb[k]);
      check(cd[k] == ed[k], $sformatf("R5 dc byte %0d", k), cd[k], ed[k]);
      check(cf[k] == ef[k], $sformatf("R6 frame of byte %0d", k), cf[k], ef[k]);
      check(ch[k] == eh[k], $sformatf("R8 sclk high time byte %0d", k), ch[k], eh[k]);
    end
    check(falls == 3, "R6 frame count", falls, 3);
    check(gap_min >= 2 * SLOW, "R6 deselect gap", gap_min, 2 * SLOW);
    check(mode_err == 0, "R7 mosi/sclk mode 0", mode_err, 0);
    check(ready_err == 0, "R9 ready outside pixel phase", ready_err, 0);
    check(done_seen == 1, "R10 done pulse count", done_seen, 1);
    check(done_bytes == n, "R10 done after last byte", done_bytes, n);
    check(busy == 0 && cs_n == 1, "R10 idle after done", {busy, cs_n}, 2'b01);
    if (inject) check(fails == f0, "R11 stray start ignored", fails - f0, 0);
  endtask

  initial begin
    mon_clear();
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cs_n == 1, "R1 cs_n reset", cs_n, 1);
    check(sclk == 0, "R1 sclk reset", sclk, 0);
    check(busy == 0, "R1 busy reset", busy, 0);
    check(done == 0, "R1 done reset", done, 0);
    check(pix_ready == 0, "R1 pix_ready reset", pix_ready, 0);
    run_win(0, 1, 0, 1, 0, 0, 16'h1234, 0);          // single pixel
    run_win(2, 6, 1, 9, 0, 3, 16'hA5A5, 0);          // 64 bytes: slow
    run_win(5, 8, 0, 11, 1, 2, 16'h0F0F, 0);         // 66 bytes: fast
    run_win(10, 26, 300, 316, 250, 700, 16'h7E11, 1); // carries, stray start
    run_win(1000, 1023, 0, 2, 1023, 0, 16'h3C3D, 0); // top of range
    run_win(7, 9, 7, 9, 0, 0, 16'h0001, 0);          // heavy stalls
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule